// File: doc/BRIEF.md
# Banked Interrupt Status Aggregator

This block gathers up to 160 event lines into five 32-bit banks, of which 137 positions are populated. Each bank has an enable register and a sticky status register. A status bit is latched when its event line goes from low to high. It stays set until software clears it by writing a one to that position. A status bit counts toward an output only while its enable bit is also set.

Banks 0, 1 and 2 form the functional group and drive `func_irq_o`. Banks 3 and 4 form the error group and drive `err_irq_o`. Both outputs are registered levels. Software reaches the registers through a small word-addressed bus with single-cycle read latency. It changes an enable by reading the whole word, altering a bit and writing the word back.

Sources are numbered by bit position, not packed densely. Event input bit n belongs to bank n/32, bit n%32. Bank 2 fills only bits 0 to 23 and bank 4 fills only bits 0 to 16, so the first error source is number 96.

Top module: `irq_bank_aggregator`

## Requirements
- R1: A rising edge on `evt_i[n]` sets the matching status bit at the clock edge where the high level is first sampled. The bit stays set after the event line returns low.
- R2: Event bit n maps to status bank n/32, bit n%32. For example, `evt_i[96]` sets bit 0 of the bank 3 status register (word address 8), and `evt_i[87]` sets bit 23 of bank 2.
- R3: A write to a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If a rising edge and a write-one-to-clear reach the same status bit at the same clock edge, the bit ends up set.
- R5: A write to an enable register stores the word, and a later read returns that exact word on the populated positions.
- R6: Unpopulated positions read as 0 in both enable and status registers, ignore writes and events, and never raise an output. The unpopulated positions are bank 2 bits 24 to 31 and bank 4 bits 17 to 31.
- R7: The register map is as follows. Word addresses 0 to 4 are the enables of banks 0 to 4. Word addresses 5 to 9 are the status registers of banks 0 to 4. Other addresses read 0 and ignore writes. Read data and `rvalid_o` appear one cycle after a read request.
- R8: `func_irq_o` is high one cycle after any bank 0 to 2 bit has both status and enable set. `err_irq_o` does the same for banks 3 and 4. A set status bit with its enable clear raises neither output.
- R9: After reset, all enable and status registers are 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 160 | Event lines, one per source number |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| func_irq_o | output | 1 | Functional group interrupt level |
| err_irq_o | output | 1 | Error group interrupt level |

## Verification
The latch-and-mask path is exercised in several ways. An event arrives with its enable clear, then the enable is opened later, which shows that masking acts after latching and not before it. Partial and full write-one-to-clear words show that only the written ones are cleared. An event edge that coincides with a clear on the same bank checks the set-wins rule. Events on source 96, on the top populated bit of bank 2 and on unpopulated positions check the bit-position numbering, the routing to each group and the unpopulated gaps.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned WORD_W         = 32;
  localparam int unsigned NUM_BANKS      = 5;
  localparam int unsigned NUM_FUNC_BANKS = 3;
  localparam int unsigned ADDR_W         = 4;
  localparam int unsigned EVT_W          = NUM_BANKS * WORD_W;

  // populated width of each bank
  function automatic int unsigned bank_pop(int unsigned b);
    case (b)
      0: return 32;
      1: return 32;
      2: return 24;
      3: return 32;
      4: return 17;
      default: return 0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pop_mask(int unsigned b);
    int unsigned n;
    n = bank_pop(b);
    if (n >= WORD_W) return '1;
    return WORD_W'((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [EVT_W-1:0] pop_flat();
    logic [EVT_W-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++) m[b*WORD_W +: WORD_W] = pop_mask(b);
    return m;
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned              WORD_W   = 32,
  parameter logic [WORD_W-1:0]        POP_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] evt_i,
  input  logic              ctrl_wr_i,
  input  logic              stat_clr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] stat_o,
  output logic              pend_o
);

  logic [WORD_W-1:0] evt_q, evt_d;
  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic [WORD_W-1:0] stat_q, stat_d;
  logic [WORD_W-1:0] rise, clr_bits;

  // next-state logic
  always_comb begin
    evt_d    = evt_i & POP_MASK;
    rise     = evt_d & ~evt_q;
    clr_bits = stat_clr_i ? wdata_i : '0;
    ctrl_d   = wdata_i & POP_MASK;
    // a new edge overrides a simultaneous clear
    stat_d   = ((stat_q & ~clr_bits) | rise) & POP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      evt_q  <= evt_d;
      stat_q <= stat_d;
      if (ctrl_wr_i) ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
  assign pend_o = |(ctrl_q & stat_q);

endmodule

// File: rtl/irq_group_or.sv
module irq_group_or #(
  parameter int unsigned NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] pend_i,
  output logic          irq_o
);

  logic irq_q, irq_d;

  always_comb irq_d = |pend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_bank_aggregator.sv
module irq_bank_aggregator
  import irq_agg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EVT_W-1:0]     evt_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic                 rvalid_o,
  output logic                 func_irq_o,
  output logic                 err_irq_o
);

  localparam int unsigned NUM_ERR_BANKS = NUM_BANKS - NUM_FUNC_BANKS;
  localparam int unsigned STAT_BASE     = NUM_BANKS;

  logic [WORD_W-1:0]    ctrl_w [NUM_BANKS];
  logic [WORD_W-1:0]    stat_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend_w;
  logic [NUM_BANKS-1:0] ctrl_wr, stat_clr;
  logic [EVT_W-1:0]     ctrl_flat, stat_flat;

  logic [WORD_W-1:0]    rdata_q, rdata_d;
  logic                 rvalid_q, rvalid_d;
  logic                 rd_en;

  // write decode
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      ctrl_wr[b]  = req_i && we_i && (int'(addr_i) == b);
      stat_clr[b] = req_i && we_i && (int'(addr_i) == STAT_BASE + b);
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    irq_src_bank #(
      .WORD_W   (WORD_W),
      .POP_MASK (pop_mask(g))
    ) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i[g*WORD_W +: WORD_W]),
      .ctrl_wr_i  (ctrl_wr[g]),
      .stat_clr_i (stat_clr[g]),
      .wdata_i    (wdata_i),
      .ctrl_o     (ctrl_w[g]),
      .stat_o     (stat_w[g]),
      .pend_o     (pend_w[g])
    );
    assign ctrl_flat[g*WORD_W +: WORD_W] = ctrl_w[g];
    assign stat_flat[g*WORD_W +: WORD_W] = stat_w[g];
  end

  irq_group_or #(.NB(NUM_FUNC_BANKS)) func_or_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(pend_w[NUM_FUNC_BANKS-1:0]),
    .irq_o (func_irq_o)
  );

  irq_group_or #(.NB(NUM_ERR_BANKS)) err_or_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(pend_w[NUM_BANKS-1:NUM_FUNC_BANKS]),
    .irq_o (err_irq_o)
  );

  // read path
  always_comb begin
    rd_en    = req_i && !we_i;
    rvalid_d = rd_en;
    rdata_d  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(addr_i) == b)             rdata_d = ctrl_w[b];
      if (int'(addr_i) == STAT_BASE + b) rdata_d = stat_w[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/irq_bank_aggregator_chk.sv
module irq_bank_aggregator_chk
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              func_irq_o,
  input logic              err_irq_o,
  input logic [EVT_W-1:0]  ctrl_flat,
  input logic [EVT_W-1:0]  stat_flat
);

  localparam int unsigned FW = NUM_FUNC_BANKS * WORD_W;
  localparam logic [EVT_W-1:0] POPF = pop_flat();

  p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i) |=> rvalid_o);

  p_no_spurious_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && !we_i) |=> !rvalid_o);

  p_ctrl_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && (int'(addr_i) < NUM_BANKS)) |=>
      rdata_o == $past(ctrl_flat[int'(addr_i)*WORD_W +: WORD_W]));

  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && we_i) |=> (($past(stat_flat) & ~stat_flat) == '0));

  p_unpop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_flat | stat_flat) & ~POPF) == '0);

  p_func_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> func_irq_o == $past(|(ctrl_flat[FW-1:0] & stat_flat[FW-1:0])));

  p_err_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> err_irq_o == $past(|(ctrl_flat[EVT_W-1:FW] & stat_flat[EVT_W-1:FW])));

endmodule

bind irq_bank_aggregator irq_bank_aggregator_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o),
  .func_irq_o (func_irq_o),
  .err_irq_o  (err_irq_o),
  .ctrl_flat  (ctrl_flat),
  .stat_flat  (stat_flat)
);

// File: tb/irq_bank_aggregator_tb_top.sv
module irq_bank_aggregator_tb_top;
  import irq_agg_pkg::*;

  logic              clk;
  logic              rst_n;
  logic [EVT_W-1:0]  evt;
  logic              req, we;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wdata;
  logic [WORD_W-1:0] rdata;
  logic              rvalid, func_irq, err_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [WORD_W-1:0] exp;
    string             tag;
  } exp_t;
  exp_t sb_q[$];

  irq_bank_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .func_irq_o(func_irq), .err_irq_o(err_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compare read results with scoreboard
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected rvalid", rdata, '0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rdata == e.exp, e.tag, rdata, e.exp);
      end
    end
  end

  task automatic rd(input int a, input logic [WORD_W-1:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    req = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(input int a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    evt[n] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    evt[n] = 1'b0;
  endtask

  task automatic chk_irq(input logic f, input logic e, input string tag);
    @(negedge clk);
    check(func_irq == f, {tag, " func"}, 32'(func_irq), 32'(f));
    check(err_irq == e,  {tag, " err"},  32'(err_irq),  32'(e));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk_irq(1'b0, 1'b0, "R9 reset");
    for (int a = 0; a < 10; a++) rd(a, '0, "R9 reset reg");

    // R5 enable readback, R6 unpopulated enable bits
    wr(0, 32'hA5A5_0001);
    rd(0, 32'hA5A5_0001, "R5 ctrl0 readback");
    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'h00FF_FFFF, "R6 ctrl2 unpopulated");
    wr(4, 32'hFFFF_FFFF);
    rd(4, 32'h0001_FFFF, "R6 ctrl4 unpopulated");

    // R7 unmapped address
    wr(13, 32'hDEAD_BEEF);
    rd(13, '0, "R7 unmapped read");
    rd(0, 32'hA5A5_0001, "R7 unmapped write ignored");

    // R1 latch while disabled, R8 masked
    pulse(5);
    rd(5, 32'h0000_0020, "R1 sticky status0");
    chk_irq(1'b0, 1'b0, "R8 masked");
    wr(0, 32'hA5A5_0021);
    chk_irq(1'b1, 1'b0, "R8 func raised");

    // R3 partial clear leaves bit 5
    wr(5, 32'h0000_0010);
    rd(5, 32'h0000_0020, "R3 zero bits kept");
    chk_irq(1'b1, 1'b0, "R3 still pending");
    wr(5, 32'h0000_0020);
    rd(5, '0, "R3 one bit cleared");
    chk_irq(1'b0, 1'b0, "R3 func dropped");

    // R2 source 96 -> bank 3 bit 0, error group
    pulse(96);
    rd(8, 32'h0000_0001, "R2 source 96");
    chk_irq(1'b0, 1'b0, "R2 masked err");
    wr(3, 32'h0000_0001);
    chk_irq(1'b0, 1'b1, "R8 err raised");

    // R4 set wins over clear in the same cycle
    @(negedge clk);
    evt[100] = 1'b1;
    req = 1'b1; we = 1'b1; addr = ADDR_W'(8); wdata = 32'h0000_0011;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    evt[100] = 1'b0;
    rd(8, 32'h0000_0010, "R4 set wins");
    chk_irq(1'b0, 1'b0, "R4 err dropped");

    // R6 unpopulated events
    pulse(2*32 + 28);
    pulse(4*32 + 20);
    rd(7, '0, "R6 bank2 gap");
    rd(9, '0, "R6 bank4 gap");
    chk_irq(1'b0, 1'b0, "R6 no irq");

    // R2 top populated bit of bank 2 (source 87)
    pulse(87);
    rd(7, 32'h0080_0000, "R2 source 87");
    chk_irq(1'b1, 1'b0, "R8 bank2 func");
    wr(7, 32'hFFFF_FFFF);
    chk_irq(1'b0, 1'b0, "R3 bank2 cleared");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R7 reads outstanding", 32'(sb_q.size()), '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule